// File: doc/BRIEF.md
# Strobed Nibble Port Controller

This block runs a 4-bit bidirectional pin group alongside an active-low, open-drain strobe line. Every timing point is counted in cycles of a 5.333 MHz clock. A request carries a 4-bit value and a per-bit direction mask. When the block accepts a request it pulls the strobe low and drives the bits marked as outputs. It lets the strobe go, then floats every data line. Next it captures the pad levels and returns them with a one-cycle completion pulse. A new request is not taken until a minimum period has passed since the previous strobe fall.

The strobe pad is read back through a two-flop synchroniser. The block counts how long the line stays low. A short external hold after the pulse has no effect on the transfer. A low that lasts too long raises a reset request, which aborts the transfer, floats the pins and clears the captured data.

The sequencer uses five named states. IDLE takes a request (IDLE->STROBE on valid). STROBE holds the strobe low (STROBE->HOLD after 32 clocks). HOLD keeps the outputs driven after the strobe rises (HOLD->WAIT at 34 clocks). WAIT has every line floating until the sample point (WAIT->GAP at the 37th edge). GAP enforces the period (GAP->IDLE at 800 clocks). An active reset request sends every state straight to IDLE.

Top module: `nib_port_ctrl`

## Requirements
- R1: While rst_n is low, stb_drive_low, pad_d_oe, done, in_nib and rst_req are all 0. After release, req_ready is 1.
- R2: A request is accepted on a clock edge where req_valid and req_ready are both 1. stb_drive_low rises on that same edge and stays 1 for exactly 32 cycles.
- R3: Direction bit i = 1 means output. From the accepting edge, pad_d_oe equals the accepted mask and pad_d_o carries the accepted value on those bits for 34 cycles. pad_d_oe is 0 from cycle 34 onward. Bits with direction 0 are never enabled.
- R4: pad_d_i is captured on the 37th edge after the accepting edge. done is 1 for exactly the one cycle that follows, and in_nib shows the captured value and holds it until the next capture.
- R5: req_ready is 0 from the accepting edge until 800 cycles after it. A request held during that time is accepted on the first edge at which req_ready is 1.
- R6: After a pulse, an external low on the strobe pad that lasts fewer than 235 synchronised cycles leaves rst_req at 0 and all data lines floating. The transfer still completes.
- R7: rst_req becomes 1 once the synchronised strobe level has been low for 235 consecutive cycles. That is 237 cycles after the pad falls in mid-cycle. It stays 1 while the pad is low and returns to 0 on the third edge after the pad goes high.
- R8: While rst_req is 1, stb_drive_low, pad_d_oe, done and req_ready are 0 and in_nib is cleared. When rst_req falls, req_ready is 1 without waiting out the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock (5.333 MHz in use) |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Block can accept a request |
| req_out | input | 4 | Value to drive on output bits |
| req_dir | input | 4 | Per-bit direction, 1 = output |
| done | output | 1 | One-cycle completion pulse |
| in_nib | output | 4 | Captured pad levels |
| pad_d_o | output | 4 | Data pad output values |
| pad_d_oe | output | 4 | Data pad output enables |
| pad_d_i | input | 4 | Data pad levels |
| stb_drive_low | output | 1 | Pulls the strobe pad low when 1 |
| stb_pad_i | input | 1 | Strobe pad level read back |
| rst_req | output | 1 | Reset request from a long strobe low |

## Verification
If the sequencer leaves a state at the wrong count, the error shows at the pins within the same transfer. The strobe or an output enable stays on a cycle too long or too short, or done appears one cycle off, and the bench checks each of these edges at the exact cycle. If the period counter is wrong, req_ready rises early or late at cycle 800. If the low-time monitor is wrong, rst_req rises away from cycle 237 or fails to clear three cycles after release. A held request, a short external hold and a reset in the middle of a transfer each exercise a state exit that a plain transfer never takes.

// File: rtl/nib_pkg.sv
package nib_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STROBE,
        ST_HOLD,
        ST_WAIT,
        ST_GAP
    } nib_state_t;
endpackage

// File: rtl/nib_sync.sv
module nib_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic meta;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= 1'b1;
            q    <= 1'b1;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/nib_lowmon.sv
module nib_lowmon #(
    parameter int LOW_LIMIT = 235
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_sync,
    output logic rst_req
);
    localparam int LW = $clog2(LOW_LIMIT + 1);
    localparam logic [LW-1:0] LIM = LW'(LOW_LIMIT);

    logic [LW-1:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            low_cnt <= '0;
        else if (line_sync)    low_cnt <= '0;
        else if (low_cnt != LIM) low_cnt <= low_cnt + 1'b1;
    end

    assign rst_req = (low_cnt == LIM);

    // R7: a request can only rise after the line was seen low
    a_r7_rise_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> $past(!line_sync));
endmodule

// File: rtl/nib_seq.sv
module nib_seq
    import nib_pkg::*;
#(
    parameter int W           = 4,
    parameter int STB_CLKS    = 32,
    parameter int REL_CLKS    = 34,
    parameter int SAMP_CLKS   = 37,
    parameter int PERIOD_CLKS = 800
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         abort,
    input  logic         req_valid,
    output logic         req_ready,
    input  logic [W-1:0] req_out,
    input  logic [W-1:0] req_dir,
    output logic         done,
    output logic [W-1:0] in_nib,
    output logic [W-1:0] pad_d_o,
    output logic [W-1:0] pad_d_oe,
    input  logic [W-1:0] pad_d_i,
    output logic         stb_drive_low
);
    localparam int CW = $clog2(PERIOD_CLKS + 1);
    localparam logic [CW-1:0] STB_END  = CW'(STB_CLKS - 1);
    localparam logic [CW-1:0] REL_END  = CW'(REL_CLKS - 1);
    localparam logic [CW-1:0] SAMP_END = CW'(SAMP_CLKS - 1);
    localparam logic [CW-1:0] PER_END  = CW'(PERIOD_CLKS - 1);

    nib_state_t    state, nxt;
    logic [CW-1:0] cnt;
    logic [W-1:0]  out_q, dir_q, in_q;
    logic          done_q;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (req_valid)       nxt = ST_STROBE;
            ST_STROBE: if (cnt == STB_END)  nxt = ST_HOLD;
            ST_HOLD:   if (cnt == REL_END)  nxt = ST_WAIT;
            ST_WAIT:   if (cnt == SAMP_END) nxt = ST_GAP;
            ST_GAP:    if (cnt == PER_END)  nxt = ST_IDLE;
            default:                        nxt = ST_IDLE;
        endcase
        if (abort) nxt = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            out_q  <= '0;
            dir_q  <= '0;
            in_q   <= '0;
            done_q <= 1'b0;
        end else if (abort) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            out_q  <= '0;
            dir_q  <= '0;
            in_q   <= '0;
            done_q <= 1'b0;
        end else begin
            state  <= nxt;
            done_q <= (state == ST_WAIT) && (nxt == ST_GAP);
            if (state == ST_IDLE) begin
                cnt <= '0;
                if (nxt == ST_STROBE) begin
                    out_q <= req_out;
                    dir_q <= req_dir;
                end
            end else begin
                cnt <= cnt + 1'b1;
            end
            if ((state == ST_WAIT) && (nxt == ST_GAP)) in_q <= pad_d_i;
        end
    end

    always_comb begin
        req_ready     = (state == ST_IDLE) && !abort;
        stb_drive_low = (state == ST_STROBE);
        pad_d_oe      = ((state == ST_STROBE) || (state == ST_HOLD)) ? dir_q : '0;
        pad_d_o       = out_q & dir_q;
        done          = done_q;
        in_nib        = in_q;
    end

    // R2: strobe falls only on an accepted handshake
    a_r2_fall_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stb_drive_low) |-> $past(req_valid && req_ready));
    // R2: the pulse is longer than one cycle
    a_r2_pulse_width: assert property (@(posedge clk) disable iff (!rst_n || abort)
        $rose(stb_drive_low) |=> stb_drive_low);
    // R3: enables at the fall match the mask offered with the request
    a_r3_mask_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stb_drive_low) |-> pad_d_oe == $past(req_dir));
    // R4: completion never overlaps driving
    a_r4_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pad_d_oe == '0) && !stb_drive_low);
    // R8: abort silences the port on the next cycle
    a_r8_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (pad_d_oe == '0) && !stb_drive_low && !done && (in_nib == '0));
endmodule

// File: rtl/nib_port_ctrl.sv
module nib_port_ctrl #(
    parameter int W             = 4,
    parameter int STB_CLKS      = 32,
    parameter int REL_CLKS      = 34,
    parameter int SAMP_CLKS     = 37,
    parameter int PERIOD_CLKS   = 800,
    parameter int RST_LOW_CLKS  = 235
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_valid,
    output logic         req_ready,
    input  logic [W-1:0] req_out,
    input  logic [W-1:0] req_dir,
    output logic         done,
    output logic [W-1:0] in_nib,
    output logic [W-1:0] pad_d_o,
    output logic [W-1:0] pad_d_oe,
    input  logic [W-1:0] pad_d_i,
    output logic         stb_drive_low,
    input  logic         stb_pad_i,
    output logic         rst_req
);
    logic stb_sync;

    nib_sync u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (stb_pad_i),
        .q     (stb_sync)
    );

    nib_lowmon #(.LOW_LIMIT(RST_LOW_CLKS)) u_lowmon (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_sync (stb_sync),
        .rst_req   (rst_req)
    );

    nib_seq #(
        .W           (W),
        .STB_CLKS    (STB_CLKS),
        .REL_CLKS    (REL_CLKS),
        .SAMP_CLKS   (SAMP_CLKS),
        .PERIOD_CLKS (PERIOD_CLKS)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .abort         (rst_req),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_out       (req_out),
        .req_dir       (req_dir),
        .done          (done),
        .in_nib        (in_nib),
        .pad_d_o       (pad_d_o),
        .pad_d_oe      (pad_d_oe),
        .pad_d_i       (pad_d_i),
        .stb_drive_low (stb_drive_low)
    );
endmodule

// File: tb/tb_nib_port_ctrl.sv
module tb_nib_port_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [3:0] req_out = '0;
    logic [3:0] req_dir = '0;
    logic       done;
    logic [3:0] in_nib;
    logic [3:0] pad_d_o;
    logic [3:0] pad_d_oe;
    logic [3:0] pad_d_i = '0;
    logic       stb_drive_low;
    logic       stb_pad_i;
    logic       rst_req;
    logic       ext_hold = 1'b0;
    int         n_run = 0;
    int         n_fail = 0;
    bit         finished = 1'b0;

    always #5 clk = ~clk;
    assign stb_pad_i = ~(stb_drive_low | ext_hold);

    nib_port_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_out(req_out), .req_dir(req_dir), .done(done), .in_nib(in_nib),
        .pad_d_o(pad_d_o), .pad_d_oe(pad_d_oe), .pad_d_i(pad_d_i),
        .stb_drive_low(stb_drive_low), .stb_pad_i(stb_pad_i), .rst_req(rst_req)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 stb", int'(stb_drive_low), 0);
        chk("R1 oe", int'(pad_d_oe), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 in_nib", int'(in_nib), 0);
        chk("R1 rst_req", int'(rst_req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready", int'(req_ready), 1);
    endtask

    // one full transfer from an idle negedge; ext_end>0 holds the pad low from cycle 32 to ext_end
    task automatic t_xfer(input logic [3:0] od, input logic [3:0] dr,
                          input logic [3:0] ia, input logic [3:0] ib, input int ext_end);
        req_out = od; req_dir = dr; req_valid = 1'b1; pad_d_i = ~ia;
        for (int k = 0; k <= 800; k++) begin
            @(negedge clk);
            if (k == 0) begin
                req_valid = 1'b0;
                chk("R2 stb fall", int'(stb_drive_low), 1);
                chk("R3 oe at fall", int'(pad_d_oe), int'(dr));
                chk("R3 data at fall", int'(pad_d_o & dr), int'(od & dr));
                chk("R5 ready low", int'(req_ready), 0);
            end
            if (k == 31) chk("R2 stb last", int'(stb_drive_low), 1);
            if (k == 32) begin
                chk("R2 stb rise", int'(stb_drive_low), 0);
                chk("R3 oe held", int'(pad_d_oe), int'(dr));
                if (ext_end > 0) ext_hold = 1'b1;
            end
            if (k == 33) chk("R3 oe last", int'(pad_d_oe), int'(dr));
            if (k == 34) chk("R3 oe released", int'(pad_d_oe), 0);
            if (k == 35) pad_d_i = ia;
            if (k == 36) chk("R4 no early done", int'(done), 0);
            if (k == 37) begin
                chk("R4 done", int'(done), 1);
                chk("R4 captured", int'(in_nib), int'(ia));
                pad_d_i = ib;
            end
            if (k == 38) begin
                chk("R4 done width", int'(done), 0);
                chk("R4 in_nib held", int'(in_nib), int'(ia));
            end
            if (ext_end > 0 && k == ext_end) begin
                chk("R6 no reset", int'(rst_req), 0);
                chk("R6 lines float", int'(pad_d_oe), 0);
                ext_hold = 1'b0;
            end
            if (ext_end > 0 && k == ext_end + 3) chk("R6 no reset after", int'(rst_req), 0);
            if (k == 799) chk("R5 ready before period", int'(req_ready), 0);
            if (k == 800) chk("R5 ready at period", int'(req_ready), 1);
        end
    endtask

    task automatic t_held_request();
        req_out = 4'h9; req_dir = 4'hF; req_valid = 1'b1;
        for (int k = 0; k <= 801; k++) begin
            @(negedge clk);
            if (k == 0) req_valid = 1'b0;
            if (k == 400) begin req_valid = 1'b1; req_out = 4'h6; req_dir = 4'h9; end
            if (k == 799) chk("R5 held waits", int'(stb_drive_low), 0);
            if (k == 800) chk("R5 held ready", int'(req_ready), 1);
            if (k == 801) begin
                req_valid = 1'b0;
                chk("R5 held accepted", int'(stb_drive_low), 1);
                chk("R5 held mask", int'(pad_d_oe), 9);
            end
        end
        repeat (800) @(negedge clk);
        chk("R5 second done idle", int'(req_ready), 1);
    endtask

    task automatic t_long_low();
        @(negedge clk);
        ext_hold = 1'b1;
        for (int k = 1; k <= 237; k++) begin
            @(negedge clk);
            if (k == 236) chk("R7 not yet", int'(rst_req), 0);
            if (k == 237) begin
                chk("R7 raised", int'(rst_req), 1);
                chk("R8 ready low", int'(req_ready), 0);
            end
        end
        repeat (20) @(negedge clk);
        chk("R7 stays", int'(rst_req), 1);
        ext_hold = 1'b0;
        for (int k = 1; k <= 3; k++) begin
            @(negedge clk);
            if (k == 2) chk("R7 still set", int'(rst_req), 1);
            if (k == 3) begin
                chk("R7 cleared", int'(rst_req), 0);
                chk("R8 ready back", int'(req_ready), 1);
            end
        end
    endtask

    task automatic t_abort();
        req_out = 4'hF; req_dir = 4'hF; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (9) @(negedge clk);
        ext_hold = 1'b1;
        repeat (260) @(negedge clk);
        chk("R8 abort rst_req", int'(rst_req), 1);
        chk("R8 abort oe", int'(pad_d_oe), 0);
        chk("R8 abort stb", int'(stb_drive_low), 0);
        chk("R8 abort in_nib", int'(in_nib), 0);
        chk("R8 abort ready", int'(req_ready), 0);
        ext_hold = 1'b0;
        repeat (4) @(negedge clk);
        chk("R8 ready no period", int'(req_ready), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_xfer(4'hA, 4'hF, 4'h3, 4'hC, 0);
        t_xfer(4'h5, 4'h3, 4'h9, 4'h6, 0);
        t_xfer(4'hF, 4'h0, 4'hE, 4'h1, 0);
        t_xfer(4'h0, 4'hC, 4'h7, 4'h8, 190);
        t_held_request();
        t_long_low();
        t_abort();
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule